// File: doc/BRIEF.md
# Variable-Rate Oversampled Data Selector

This block sits behind an oversampling front end that captures each bit period several times. Every accepted window holds OSR × NBITS samples (20 by default: four bit periods of five samples each). A fine-phase value from an upstream detector gives the average transition position in the window, in sample units. The block turns that value into a sampling phase half a bit period away from the transition. For every bit period it then picks the sample at that phase.

The window boundary does not move with the data. When the sampling point drifts across it, a window can carry one bit more or one bit less than usual. The block compares the current sampling phase with the one kept from the previous accepted window and raises one of two size flags. It always emits a word of NBITS+1 bits. The extra top bit is taken straight from the first sample of the window, so the downstream packer only chooses how many low bits to keep.

Both sides are valid/ready streams. A window is accepted on a clock edge where `win_valid` and `win_ready` are both high. The result is registered and held until the consumer takes it. `win_ready` is high whenever the output register is empty or is being drained in the same cycle, so back-pressure passes straight through with no extra storage.

Top module: `ovs_bit_picker`

## Requirements
- R1: The sampling phase is (fine phase + 3) mod 5, and the bit of period k is sample 5k + sampling phase. `win_samples[i]` is sample i, sample 0 is the earliest, and a legal fine phase is 0 to 4.
- R2: `pick_bits[4]` carries sample 0 of the window. `pick_bits[3-k]` carries the bit selected for period k, k = 0..3.
- R3: `pick_more` is set exactly when the (previous, current) sampling phases are (3,0), (4,0) or (4,1). The window then yields five bits, `pick_bits[4:0]`.
- R4: `pick_less` is set exactly when the (previous, current) sampling phases are (0,3), (0,4) or (1,4). The window then yields three bits, `pick_bits[2:0]`.
- R5: In every other pair both flags are low and the window yields four bits, `pick_bits[3:0]`. The two flags are never high together.
- R6: The previous phase is the sampling phase of the last accepted window. It resets to 2 and changes only when a window is accepted.
- R7: A window accepted at a clock edge appears on the outputs with `pick_valid` high right after that edge.
- R8: `win_ready` = !`pick_valid` || `pick_ready`. While `pick_valid` is high and `pick_ready` is low, the outputs keep their values.
- R9: During and after reset, `pick_valid`, `pick_more` and `pick_less` are low and `win_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | Sample window offered |
| win_ready | output | 1 | Block can accept a window |
| win_samples | input | 20 | Oversampled window, bit i = sample i |
| win_fine | input | 3 | Fine phase of the window, 0..4 |
| pick_valid | output | 1 | Result word held |
| pick_ready | input | 1 | Consumer takes the result |
| pick_bits | output | 5 | Bypass bit on top, selected bits below |
| pick_more | output | 1 | Window yields five bits |
| pick_less | output | 1 | Window yields three bits |

## Verification
The bench steps the sampling phase through all 25 ordered (previous, current) pairs, so a design that wraps the circular distance wrongly would flag the far pairs (3,1) or (1,3), or miss (4,0). The window contents are pseudo-random, so a mux offset by one sample, a reversed bit order or a bypass bit taken from the wrong end produces wrong words. Under random back-pressure the bench offers windows that are refused. A design that updated its stored phase on a refused window would give wrong flags on the next accepted one, and a design that let a held result change would fail the hold checks. The first window after reset has sampling phase 0, which catches a wrong reset phase.

// File: rtl/ovs_pick_pkg.sv
package ovs_pick_pkg;
  typedef enum logic [1:0] {
    SZ_NORM = 2'd0,
    SZ_MORE = 2'd1,
    SZ_LESS = 2'd2
  } size_e;
endpackage

// File: rtl/ovs_phase_map.sv
// Turns the transition position into the sampling position half a bit away.
module ovs_phase_map #(
  parameter int OSR = 5,
  parameter int PW  = 3
) (
  input  logic [PW-1:0] fine,
  output logic [PW-1:0] samp
);
  localparam int OFF = (OSR + 1) / 2;
  localparam logic [PW:0] OFF_V = (PW+1)'(OFF);
  localparam logic [PW:0] OSR_V = (PW+1)'(OSR);

  logic [PW:0] sum;

  always_comb begin
    sum = {1'b0, fine} + OFF_V;
    if (sum >= OSR_V) sum = sum - OSR_V;
    samp = sum[PW-1:0];
  end
endmodule

// File: rtl/ovs_bit_mux.sv
// One OSR-to-1 selector per bit period; period 0 lands in the top bit.
module ovs_bit_mux #(
  parameter int OSR   = 5,
  parameter int NBITS = 4,
  parameter int PW    = 3
) (
  input  logic [OSR*NBITS-1:0] win,
  input  logic [PW-1:0]        samp,
  output logic [NBITS-1:0]     picked
);
  for (genvar k = 0; k < NBITS; k++) begin : g_period
    logic [OSR-1:0] grp;
    assign grp = win[k*OSR +: OSR];
    assign picked[NBITS-1-k] = grp[samp];
  end
endmodule

// File: rtl/ovs_size_judge.sv
// Decides whether the sampling point crossed the window boundary.
module ovs_size_judge
  import ovs_pick_pkg::*;
#(
  parameter int OSR = 5,
  parameter int PW  = 3
) (
  input  logic [PW-1:0] prev_s,
  input  logic [PW-1:0] cur_s,
  output size_e         size
);
  localparam int HALF = OSR / 2;

  int d_up;
  int d_dn;

  always_comb begin
    d_up = (int'(cur_s) - int'(prev_s) + OSR) % OSR;
    d_dn = (int'(prev_s) - int'(cur_s) + OSR) % OSR;
    size = SZ_NORM;
    if (cur_s < prev_s && d_up <= HALF)      size = SZ_MORE;
    else if (cur_s > prev_s && d_dn <= HALF) size = SZ_LESS;
  end
endmodule

// File: rtl/ovs_bit_picker.sv
module ovs_bit_picker
  import ovs_pick_pkg::*;
#(
  parameter int OSR   = 5,
  parameter int NBITS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       win_valid,
  output logic                       win_ready,
  input  logic [OSR*NBITS-1:0]       win_samples,
  input  logic [$clog2(OSR)-1:0]     win_fine,
  output logic                       pick_valid,
  input  logic                       pick_ready,
  output logic [NBITS:0]             pick_bits,
  output logic                       pick_more,
  output logic                       pick_less
);
  localparam int PW = $clog2(OSR);
  localparam logic [PW-1:0] RST_PHASE = PW'(OSR / 2);

  logic [PW-1:0]    cur_s;
  logic [PW-1:0]    prev_s;
  logic [NBITS-1:0] picked;
  size_e            size;
  logic             accept;

  ovs_phase_map #(.OSR(OSR), .PW(PW)) i_map (
    .fine (win_fine),
    .samp (cur_s)
  );

  ovs_bit_mux #(.OSR(OSR), .NBITS(NBITS), .PW(PW)) i_mux (
    .win    (win_samples),
    .samp   (cur_s),
    .picked (picked)
  );

  ovs_size_judge #(.OSR(OSR), .PW(PW)) i_judge (
    .prev_s (prev_s),
    .cur_s  (cur_s),
    .size   (size)
  );

  assign win_ready = !pick_valid || pick_ready;
  assign accept    = win_valid && win_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_s     <= RST_PHASE;
      pick_valid <= 1'b0;
      pick_bits  <= '0;
      pick_more  <= 1'b0;
      pick_less  <= 1'b0;
    end else if (accept) begin
      prev_s     <= cur_s;
      pick_valid <= 1'b1;
      pick_bits  <= {win_samples[0], picked};
      pick_more  <= (size == SZ_MORE);
      pick_less  <= (size == SZ_LESS);
    end else if (pick_ready) begin
      pick_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ovs_bit_picker_chk.sv
module ovs_bit_picker_chk #(
  parameter int OSR   = 5,
  parameter int NBITS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   win_valid,
  input logic                   win_ready,
  input logic [$clog2(OSR)-1:0] win_fine,
  input logic                   pick_valid,
  input logic                   pick_ready,
  input logic [NBITS:0]         pick_bits,
  input logic                   pick_more,
  input logic                   pick_less
);
  // R5
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pick_more && pick_less));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_valid && !pick_ready) |=>
      (pick_valid && $stable(pick_bits) && $stable(pick_more) && $stable(pick_less)));

  // R8
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> win_ready);

  // R7
  rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pick_valid) |-> $past(win_valid && win_ready));

  // R1
  fine_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (int'(win_fine) < OSR));
endmodule

bind ovs_bit_picker ovs_bit_picker_chk #(.OSR(OSR), .NBITS(NBITS)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .win_valid  (win_valid),
  .win_ready  (win_ready),
  .win_fine   (win_fine),
  .pick_valid (pick_valid),
  .pick_ready (pick_ready),
  .pick_bits  (pick_bits),
  .pick_more  (pick_more),
  .pick_less  (pick_less)
);

// File: tb/test_ovs_bit_picker.sv
`timescale 1ns/100ps
module test_ovs_bit_picker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_valid = 1'b0;
  logic        win_ready;
  logic [19:0] win_samples = '0;
  logic [2:0]  win_fine = '0;
  logic        pick_valid;
  logic        pick_ready = 1'b1;
  logic [4:0]  pick_bits;
  logic        pick_more;
  logic        pick_less;

  int checks = 0;
  int fails = 0;
  int model_prev = 2;
  int unsigned seed = 32'h1234_5678;
  bit bp_on = 1'b0;
  logic [6:0] exp_q[$];

  always #2.5 clk = ~clk;

  ovs_bit_picker i_ovs_bit_picker (
    .clk (clk), .rst_n (rst_n),
    .win_valid (win_valid), .win_ready (win_ready),
    .win_samples (win_samples), .win_fine (win_fine),
    .pick_valid (pick_valid), .pick_ready (pick_ready),
    .pick_bits (pick_bits), .pick_more (pick_more), .pick_less (pick_less)
  );

  function automatic int unsigned next_rand(ref int unsigned s);
    s = s * 32'd1103515245 + 32'd12345;
    return s;
  endfunction

  // Result layout: {more, less, bits[4:0]}
  function automatic logic [6:0] model(logic [19:0] w, int f, int p);
    int s;
    logic [4:0] b;
    logic m, l;
    s = (f + 3) % 5;
    b[4] = w[0];
    for (int k = 0; k < 4; k++) b[3-k] = w[5*k + s];
    m = (p == 3 && s == 0) || (p == 4 && s == 0) || (p == 4 && s == 1);
    l = (p == 0 && s == 3) || (p == 0 && s == 4) || (p == 1 && s == 4);
    return {m, l, b};
  endfunction

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic send(input logic [19:0] w, input int f);
    @(negedge clk);
    win_valid = 1'b1; win_samples = w; win_fine = 3'(f);
    #1;
    while (!win_ready) begin
      // R8: refused while a held result is not taken
      check(pick_valid && !pick_ready,
            $sformatf("R8 win_ready low with valid=%0b ready=%0b exp valid=1 ready=0",
                      pick_valid, pick_ready));
      @(negedge clk); #1;
    end
    exp_q.push_back(model(w, f, model_prev));
    model_prev = (f + 3) % 5;
    @(posedge clk); #1;
    win_valid = 1'b0;
    // R7: result registered right after the accepting edge
    check(pick_valid === 1'b1, $sformatf("R7 pick_valid act=%0b exp=1", pick_valid));
  endtask

  // back-pressure driver
  initial begin
    forever begin
      @(negedge clk);
      if (bp_on) pick_ready = next_rand(seed) [20];
      else       pick_ready = 1'b1;
    end
  end

  // scoreboard monitor
  initial begin
    logic [6:0] held;
    bit was_held;
    was_held = 1'b0;
    held = '0;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (was_held) begin
          // R8: held output must not change
          check(pick_valid && {pick_more, pick_less, pick_bits} == held,
                $sformatf("R8 hold act=%b/%0b exp=%b/1", {pick_more, pick_less, pick_bits},
                          pick_valid, held));
        end
        if (pick_valid && pick_ready) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R7 output with empty scoreboard act=1 exp=0");
          end else begin
            logic [6:0] e;
            e = exp_q.pop_front();
            // R1 R2: selected bits and bypass bit
            check(pick_bits == e[4:0],
                  $sformatf("R1/R2 bits act=%b exp=%b", pick_bits, e[4:0]));
            if (e[6])
              check({pick_more, pick_less} == e[6:5],
                    $sformatf("R3/R6 flags act=%b exp=%b", {pick_more, pick_less}, e[6:5]));
            else if (e[5])
              check({pick_more, pick_less} == e[6:5],
                    $sformatf("R4/R6 flags act=%b exp=%b", {pick_more, pick_less}, e[6:5]));
            else
              check({pick_more, pick_less} == e[6:5],
                    $sformatf("R5/R6 flags act=%b exp=%b", {pick_more, pick_less}, e[6:5]));
          end
        end
        was_held = pick_valid && !pick_ready;
        held = {pick_more, pick_less, pick_bits};
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: reset state
    check(pick_valid === 1'b0 && pick_more === 1'b0 && pick_less === 1'b0 && win_ready === 1'b1,
          $sformatf("R9 reset valid=%0b more=%0b less=%0b ready=%0b exp 0 0 0 1",
                    pick_valid, pick_more, pick_less, win_ready));
    @(negedge clk);
    rst_n = 1'b1;

    // R6: first window after reset, phase 0 against reset phase 2 -> four bits
    send(20'hA5C3E, 2);

    // R3 R4 R5: walk every ordered pair of sampling phases
    for (int p = 0; p < 5; p++)
      for (int c = 0; c < 5; c++) begin
        send(20'(next_rand(seed)), (p + 2) % 5);
        send(20'(next_rand(seed)), (c + 2) % 5);
      end

    // R8 R6: random back-pressure, refused windows keep the stored phase
    bp_on = 1'b1;
    for (int i = 0; i < 60; i++)
      send(20'(next_rand(seed)), int'(next_rand(seed) % 5));
    bp_on = 1'b0;

    // drain
    for (int i = 0; i < 20 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, $sformatf("R7 pending results act=%0d exp=0", exp_q.size()));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule